// File: doc/BRIEF.md
# Adaptive Bit-Center Sampler for a Low/Full-Speed Serial Line

This block recovers bit timing from a stream of line symbols that have already been classified as J, K, single-ended zero or single-ended one. A start-of-packet pulse from the framer marks the first J-to-K transition of a packet. From that point the block keeps a fractional bit-period accumulator and issues one center strobe per bit, carrying the symbol seen at that moment. It also issues an edge-check strobe roughly half a bit before each center after the first, carrying the symbol seen where the transition is expected.

When a bit carries a transition, the block compares the edge-check symbol with the center symbol. The comparison shows whether the line edge arrived early or late. The block then trims the bit period by a small step and moves the next sample point by a larger one, so that sampling follows a transmitter whose clock is off by up to about two percent. The framer drops a stop input to end sampling. Symbol classification, bit destuffing and packet decoding are left to neighbouring blocks.

Top module: `usbs_bit_sampler`

## Requirements
- R1: Line symbols are 2-bit codes: 2'b00 single-ended zero, 2'b01 J, 2'b10 K, 2'b11 single-ended one. After reset, and until the first start pulse, neither strobe is raised.
- R2: On a start pulse the bit period P (unsigned, 8 fractional bits, in clock cycles) is reloaded with floor(CLK_HZ*256/1_500_000) if the rate select is 1 (low rate) or floor(CLK_HZ*256/12_000_000) if it is 0 (full rate). The rate select is sampled only on the start pulse.
- R3: Let the start pulse be sampled on clock edge t0. The first center then falls on edge floor(X/256), where X = 256*t0 + (P>>1) + 128. A center strobe is high for the one cycle after that edge, and the center symbol output holds the input symbol sampled on that edge.
- R4: After each center at position X, the next position is X + P' plus the phase step of R6, where P' is the period after R6 and R7 are applied. The edge-check strobe for that next bit follows edge floor((X_next - (P'>>1))/256) and carries the symbol sampled there. The first bit of a packet has no edge-check strobe.
- R5: A center trims period and phase only when all of the following hold: its symbol is J or K; its symbol differs from the previous center symbol (J is taken as the previous symbol right after a start pulse); an edge-check strobe occurred for this bit; and the edge-check symbol is J or K.
- R6: When the edge-check symbol equals the center symbol, the edge came early: P' = P - (P>>10) and X_next is reduced by (P'>>7)+(P'>>9). Otherwise the edge came late: P' = P + (P>>10) and X_next is increased by the same amount.
- R7: P is clamped to the range floor(Pnom*49/50) to floor(Pnom*51/50), where Pnom is the nominal period of the rate latched at the start pulse.
- R8: A high stop input stops sampling on that edge. No strobe follows until a later start pulse. Stop takes priority over a start pulse on the same edge.
- R9: A start pulse during a packet restarts timing from that pulse and reloads the nominal period, and no strobe follows the edge on which the start pulse is sampled.
- R10: The two strobes are never high in the same cycle, and a center strobe is never high in two consecutive cycles. The nominal period must be at least 3 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_sym_i | input | 2 | Classified line symbol (code per R1) |
| sop_i | input | 1 | Start-of-packet pulse, one cycle, on the first K |
| rate_ls_i | input | 1 | Rate select: 1 low rate, 0 full rate |
| halt_i | input | 1 | Stop sampling |
| ctr_stb_o | output | 1 | Bit-center strobe |
| ctr_sym_o | output | 2 | Symbol sampled at the bit center |
| edge_stb_o | output | 1 | Edge-check strobe |
| edge_sym_o | output | 2 | Symbol sampled at the edge-check point |

## Verification
The bench builds the block with CLK_HZ = 39_000_000. That gives a full-rate period of 3.25 cycles, so the fractional part of the accumulator changes every bit and sample points land on irregular cycles. The low-rate period is 26 cycles. There the 0.1% period step is 6 LSB, large enough for one packet to walk the period into either clamp. At full rate the period step rounds to zero and only the phase step acts, which covers the case where the two corrections come apart. The bench sweeps transmitter periods from -3% to +3% in both rates, and adds a stop in mid-packet and a restart in mid-packet.

// File: rtl/usbs_pkg.sv
// Package: shared symbol codes and rate constants for the bit-center sampler.
// Assumes symbols arrive already classified from the two line wires.
package usbs_pkg;
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_J   = 2'b01,
        LN_K   = 2'b10,
        LN_SE1 = 2'b11
    } line_sym_t;

    localparam int unsigned FRAC_BITS = 8;
    localparam int unsigned RATE_LS   = 1_500_000;
    localparam int unsigned RATE_FS   = 12_000_000;

    // True for the two differential data symbols.
    function automatic logic is_data_sym(input logic [1:0] s);
        return (s == LN_J) || (s == LN_K);
    endfunction
endpackage

// File: rtl/usbs_period_trim.sv
// Module: holds the current bit period (8 fractional bits) and works out
// the trimmed period and phase step for the next bit.
// Assumes trim_i is only raised on a center-firing cycle, and load_i on a start.
module usbs_period_trim #(
    parameter int unsigned PW     = 15,
    parameter int unsigned PER_FS = 1024,
    parameter int unsigned PER_LS = 8192
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          ls_i,
    input  logic          trim_i,
    input  logic          early_i,
    output logic [PW-1:0] per_o,
    output logic          ls_o,
    output logic [PW-1:0] per_nxt_o,
    output logic [PW-1:0] adj_o
);
    localparam logic [PW-1:0] LO_FS = PW'(PER_FS * 49 / 50);
    localparam logic [PW-1:0] HI_FS = PW'(PER_FS * 51 / 50);
    localparam logic [PW-1:0] LO_LS = PW'(PER_LS * 49 / 50);
    localparam logic [PW-1:0] HI_LS = PW'(PER_LS * 51 / 50);

    logic [PW-1:0] per_q;
    logic          ls_q;
    logic [PW-1:0] step, lo, hi, dn;
    logic [PW:0]   up;

    // Clamped one-step trim of the period, and phase step from the result.
    always_comb begin
        step = per_q >> 10;
        lo   = ls_q ? LO_LS : LO_FS;
        hi   = ls_q ? HI_LS : HI_FS;
        dn   = per_q - step;
        up   = {1'b0, per_q} + {1'b0, step};
        if (!trim_i)
            per_nxt_o = per_q;
        else if (early_i)
            per_nxt_o = (dn < lo) ? lo : dn;
        else
            per_nxt_o = (up > {1'b0, hi}) ? hi : up[PW-1:0];
        adj_o = (per_nxt_o >> 7) + (per_nxt_o >> 9);
    end

    // Period register: nominal on start, trimmed value on correcting centers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= PW'(PER_FS);
            ls_q  <= 1'b0;
        end else if (load_i) begin
            per_q <= ls_i ? PW'(PER_LS) : PW'(PER_FS);
            ls_q  <= ls_i;
        end else if (trim_i) begin
            per_q <= per_nxt_o;
        end
    end

    assign per_o = per_q;
    assign ls_o  = ls_q;
endmodule

// File: rtl/usbs_phase_timer.sv
// Module: two fractional down-counters, one to the next bit center and one
// to the edge-check point before it. Each drops one cycle (256) per clock.
// Assumes the period is at least 3 cycles, so both counters stay non-negative.
module usbs_phase_timer #(
    parameter int unsigned PW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sop_i,
    input  logic          halt_i,
    input  logic [PW-1:0] ld_half_i,
    input  logic [PW-1:0] per_nxt_i,
    input  logic [PW-1:0] adj_i,
    input  logic          trim_i,
    input  logic          early_i,
    output logic          ctr_fire_o,
    output logic          edge_fire_o
);
    localparam int unsigned RW = PW + 1;
    localparam logic [RW-1:0] ONE = RW'(256);

    logic [RW-1:0] rem_q, erem_q, base, rem_nx, erem_ld;
    logic          run_q, earm_q, open;

    // Firing decisions and reload values for a firing center.
    always_comb begin
        open        = run_q && !halt_i && !sop_i;
        ctr_fire_o  = open && (rem_q[RW-1:8] == '0);
        edge_fire_o = open && earm_q && (erem_q[RW-1:8] == '0);
        base        = rem_q + RW'(per_nxt_i) - ONE;
        if (!trim_i)
            rem_nx = base;
        else if (early_i)
            rem_nx = base - RW'(adj_i);
        else
            rem_nx = base + RW'(adj_i);
        erem_ld = rem_nx - RW'(per_nxt_i >> 1);
    end

    // Counter state: stop, restart, reload on a center, or count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            earm_q <= 1'b0;
            rem_q  <= '0;
            erem_q <= '0;
        end else if (halt_i) begin
            run_q  <= 1'b0;
            earm_q <= 1'b0;
        end else if (sop_i) begin
            run_q  <= 1'b1;
            earm_q <= 1'b0;
            rem_q  <= RW'(ld_half_i) - RW'(128);
        end else if (run_q) begin
            if (ctr_fire_o) begin
                rem_q  <= rem_nx;
                erem_q <= erem_ld;
                earm_q <= 1'b1;
            end else begin
                rem_q <= rem_q - ONE;
                if (edge_fire_o)
                    earm_q <= 1'b0;
                else if (earm_q)
                    erem_q <= erem_q - ONE;
            end
        end
    end
endmodule

// File: rtl/usbs_bit_sampler.sv
// Module: top of the adaptive bit-center sampler. It ties the period trimmer
// to the phase timer, decides on each transition-carrying bit whether the edge
// was early or late, and registers both strobes with their symbols.
// Assumes CLK_HZ gives a nominal full-rate period of at least 3 cycles.
module usbs_bit_sampler
    import usbs_pkg::*;
#(
    parameter int unsigned CLK_HZ = 48_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_sym_i,
    input  logic       sop_i,
    input  logic       rate_ls_i,
    input  logic       halt_i,
    output logic       ctr_stb_o,
    output logic [1:0] ctr_sym_o,
    output logic       edge_stb_o,
    output logic [1:0] edge_sym_o
);
    localparam int unsigned PER_FS = 32'((64'(CLK_HZ) * 64'd256) / 64'(RATE_FS));
    localparam int unsigned PER_LS = 32'((64'(CLK_HZ) * 64'd256) / 64'(RATE_LS));
    localparam int unsigned PW     = $clog2(PER_LS * 51 / 50 + 1) + 1;

    logic [PW-1:0] per_cur, per_nxt, adj, nom_sel;
    logic          ls_cur, ctr_fire, edge_fire, trim, early, start;
    logic [1:0]    prev_q, esym_q;
    logic          eseen_q;

    // Correction decision for the bit whose center fires on this edge.
    always_comb begin
        start   = sop_i && !halt_i;
        nom_sel = rate_ls_i ? PW'(PER_LS) : PW'(PER_FS);
        early   = (esym_q == line_sym_i);
        trim    = ctr_fire && is_data_sym(line_sym_i) && (line_sym_i != prev_q)
                  && eseen_q && is_data_sym(esym_q);
    end

    usbs_period_trim #(.PW(PW), .PER_FS(PER_FS), .PER_LS(PER_LS)) u_trim (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (start),
        .ls_i     (rate_ls_i),
        .trim_i   (trim),
        .early_i  (early),
        .per_o    (per_cur),
        .ls_o     (ls_cur),
        .per_nxt_o(per_nxt),
        .adj_o    (adj)
    );

    usbs_phase_timer #(.PW(PW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sop_i      (sop_i),
        .halt_i     (halt_i),
        .ld_half_i  (nom_sel >> 1),
        .per_nxt_i  (per_nxt),
        .adj_i      (adj),
        .trim_i     (trim),
        .early_i    (early),
        .ctr_fire_o (ctr_fire),
        .edge_fire_o(edge_fire)
    );

    // Per-bit history: previous center symbol and the latched edge-check symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= LN_J;
            esym_q  <= LN_J;
            eseen_q <= 1'b0;
        end else if (start) begin
            prev_q  <= LN_J;
            eseen_q <= 1'b0;
        end else if (ctr_fire) begin
            prev_q  <= line_sym_i;
            eseen_q <= 1'b0;
        end else if (edge_fire) begin
            esym_q  <= line_sym_i;
            eseen_q <= 1'b1;
        end
    end

    // Registered strobes; symbols hold between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_stb_o  <= 1'b0;
            edge_stb_o <= 1'b0;
            ctr_sym_o  <= LN_J;
            edge_sym_o <= LN_J;
        end else begin
            ctr_stb_o  <= ctr_fire;
            edge_stb_o <= edge_fire;
            if (ctr_fire)
                ctr_sym_o <= line_sym_i;
            if (edge_fire)
                edge_sym_o <= line_sym_i;
        end
    end
endmodule

// File: rtl/usbs_bit_sampler_chk.sv
// Checker: temporal properties of the bit-center sampler, bound to its top.
// Assumes the same parameters as the top it is bound to.
module usbs_bit_sampler_chk #(
    parameter int unsigned PW     = 15,
    parameter int unsigned PER_FS = 1024,
    parameter int unsigned PER_LS = 8192
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    line_sym_i,
    input logic          sop_i,
    input logic          halt_i,
    input logic          ctr_stb_o,
    input logic [1:0]    ctr_sym_o,
    input logic          edge_stb_o,
    input logic [PW-1:0] per_cur,
    input logic          ls_cur
);
    localparam int unsigned LO_FS = PER_FS * 49 / 50;
    localparam int unsigned HI_FS = PER_FS * 51 / 50;
    localparam int unsigned LO_LS = PER_LS * 49 / 50;
    localparam int unsigned HI_LS = PER_LS * 51 / 50;

    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctr_stb_o && edge_stb_o)); // R10
    AST_CTR_NOT_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_stb_o |=> !ctr_stb_o); // R10
    AST_HALT_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> (!ctr_stb_o && !edge_stb_o)); // R8
    AST_SOP_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        sop_i |=> (!ctr_stb_o && !edge_stb_o)); // R9
    AST_CTR_SYM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && ctr_stb_o) |-> (ctr_sym_o == $past(line_sym_i))); // R3
    AST_PERIOD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ls_cur ? (32'(per_cur) >= LO_LS && 32'(per_cur) <= HI_LS)
               : (32'(per_cur) >= LO_FS && 32'(per_cur) <= HI_FS)); // R7
endmodule

bind usbs_bit_sampler usbs_bit_sampler_chk #(
    .PW(PW), .PER_FS(PER_FS), .PER_LS(PER_LS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_sym_i(line_sym_i),
    .sop_i     (sop_i),
    .halt_i    (halt_i),
    .ctr_stb_o (ctr_stb_o),
    .ctr_sym_o (ctr_sym_o),
    .edge_stb_o(edge_stb_o),
    .per_cur   (per_cur),
    .ls_cur    (ls_cur)
);

// File: tb/usbs_bit_sampler_tb.sv
`timescale 1ns/1ps
// Bench: sweeps transmitter skew at both rates against an arithmetic model
// of the sample-point equations from the requirements.
module usbs_bit_sampler_tb_top;
    localparam int unsigned CLK_HZ = 39_000_000;
    localparam longint PFS = (longint'(CLK_HZ) * 256) / 12_000_000;
    localparam longint PLS = (longint'(CLK_HZ) * 256) / 1_500_000;
    localparam logic [1:0] C_SE0 = 2'b00, C_J = 2'b01, C_K = 2'b10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] line_sym_i = C_J;
    logic sop_i = 1'b0, rate_ls_i = 1'b0, halt_i = 1'b0;
    logic ctr_stb_o, edge_stb_o;
    logic [1:0] ctr_sym_o, edge_sym_o;

    usbs_bit_sampler #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_sym_i(line_sym_i), .sop_i(sop_i),
        .rate_ls_i(rate_ls_i), .halt_i(halt_i), .ctr_stb_o(ctr_stb_o),
        .ctr_sym_o(ctr_sym_o), .edge_stb_o(edge_stb_o), .edge_sym_o(edge_sym_o)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    string tag = "R1";
    longint cyc = 0;

    // model state
    bit act = 0, epend = 0, eseen = 0, lsm = 0;
    longint pos = 0, epos = 0, per = PFS;
    logic [1:0] prev = C_J, esym = C_J;
    bit e_cs = 0, e_es = 0;
    logic [1:0] e_csym = C_J, e_esym = C_J;

    // line waveform
    logic [1:0] lv [64];
    longint cs = 0, tl = 256;

    function automatic bit isd(input logic [1:0] s);
        return (s == C_J) || (s == C_K);
    endfunction

    function automatic logic [1:0] line_at(input longint c);
        longint idx;
        if (c < cs) return C_J;
        idx = ((c - cs) * 256) / tl;
        return (idx < 64) ? lv[idx] : C_J;
    endfunction

    task automatic build_line(input logic [31:0] data);
        logic [1:0] lvl = C_J;
        for (int i = 0; i < 64; i++) begin
            if (i < 32) begin
                if (!data[i]) lvl = (lvl == C_J) ? C_K : C_J;
                lv[i] = lvl;
            end else if (i < 34) lv[i] = C_SE0;
            else lv[i] = C_J;
        end
    endtask

    task automatic compare();
        n_chk++;
        if (ctr_stb_o !== e_cs || (e_cs && ctr_sym_o !== e_csym)) begin
            n_bad++;
            $display("FAIL %s R4 R5 ctr cyc=%0d: stb=%0d sym=%0d expected stb=%0d sym=%0d",
                     tag, cyc, ctr_stb_o, ctr_sym_o, e_cs, e_csym);
        end
        n_chk++;
        if (edge_stb_o !== e_es || (e_es && edge_sym_o !== e_esym)) begin
            n_bad++;
            $display("FAIL %s R4 edge cyc=%0d: stb=%0d sym=%0d expected stb=%0d sym=%0d",
                     tag, cyc, edge_stb_o, edge_sym_o, e_es, e_esym);
        end
        n_chk++;
        if (ctr_stb_o && edge_stb_o) begin
            n_bad++;
            $display("FAIL R10 coincident strobes: ctr=%0d edge=%0d expected not both",
                     ctr_stb_o, edge_stb_o);
        end
    endtask

    // Model of one clock edge with the inputs about to be sampled.
    task automatic model(input logic [1:0] s, input bit sop, input bit halt, input bit rate);
        bit cf, ef, tr, early;
        longint pn, adj, lo, hi;
        cf = act && !halt && !sop && ((pos >> 8) <= cyc);
        ef = act && !halt && !sop && epend && ((epos >> 8) <= cyc);
        e_cs = cf; e_es = ef;
        if (cf) e_csym = s;
        if (ef) e_esym = s;
        if (cf) begin
            tr = isd(s) && (s != prev) && eseen && isd(esym);
            early = (esym == s);
            lo = lsm ? (PLS * 49) / 50 : (PFS * 49) / 50;
            hi = lsm ? (PLS * 51) / 50 : (PFS * 51) / 50;
            pn = per;
            if (tr) pn = early ? per - (per >> 10) : per + (per >> 10);
            if (pn < lo) pn = lo;
            if (pn > hi) pn = hi;
            adj = (pn >> 7) + (pn >> 9);
            pos = pos + pn + (tr ? (early ? -adj : adj) : 0);
            per = pn;
            epos = pos - (pn >> 1);
            epend = 1; eseen = 0; prev = s;
        end
        if (ef) begin epend = 0; eseen = 1; esym = s; end
        if (halt) act = 0;
        else if (sop) begin
            act = 1; lsm = rate; per = rate ? PLS : PFS;
            pos = cyc * 256 + (per >> 1) + 128;
            epend = 0; eseen = 0; prev = C_J;
        end
    endtask

    task automatic step(input logic [1:0] s, input bit sop, input bit halt);
        @(negedge clk);
        compare();
        line_sym_i = s; sop_i = sop; halt_i = halt;
        model(s, sop, halt, rate_ls_i);
        cyc++;
    endtask

    // One packet: idle J, start pulse, optional restart and stop, then a stop.
    task automatic run_packet(input bit rate, input int skew_permil, input logic [31:0] data,
                              input longint len, input longint halt_at, input longint rs_at);
        longint base;
        rate_ls_i = rate;
        build_line(data);
        tl = ((rate ? PLS : PFS) * (1000 + skew_permil)) / 1000;
        base = cyc;
        cs = base + 3;
        for (longint i = 0; i < len; i++) begin
            if (rs_at >= 0 && cyc == base + rs_at) cs = cyc;
            step(line_at(cyc), (cyc == cs), (halt_at >= 0 && cyc == base + halt_at));
        end
        step(C_J, 1'b0, 1'b1);
        step(C_J, 1'b0, 1'b0);
    endtask

    initial begin
        #(4 * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        end
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset, no strobes without a start pulse
        tag = "R1";
        for (int i = 0; i < 40; i++) step(C_J, 1'b0, 1'b0);
        step(C_SE0, 1'b0, 1'b0);
        step(C_K, 1'b0, 1'b0);
        // R3: nominal full rate; R2: nominal low rate
        tag = "R3";
        run_packet(1'b0, 0, 32'hB36E_1580, 140, -1, -1);
        tag = "R2";
        run_packet(1'b1, 0, 32'hB36E_1580, 960, -1, -1);
        // R6: skew sweep at both rates
        tag = "R6";
        for (int k = -6; k <= 6; k++) begin
            run_packet(1'b0, k * 5, (k % 2 == 0) ? 32'h5A3C_E680 : 32'h0F0F_0A80, 140, -1, -1);
            run_packet(1'b1, k * 5, (k % 2 == 0) ? 32'h5A3C_E680 : 32'h0F0F_0A80, 960, -1, -1);
        end
        // R7: heavy skew drives the period into its clamps
        tag = "R7";
        run_packet(1'b1, 40, 32'h0000_0080, 960, -1, -1);
        run_packet(1'b1, -40, 32'h0000_0080, 960, -1, -1);
        // R8: stop mid-packet, then stop and start on the same edge
        tag = "R8";
        run_packet(1'b1, 10, 32'h0000_0080, 700, 300, -1);
        run_packet(1'b0, 0, 32'h0000_0080, 100, 3, -1);
        // R9: restart mid-packet at the other alignment
        tag = "R9";
        run_packet(1'b1, -10, 32'h1234_5680, 1100, -1, 250);
        run_packet(1'b0, 15, 32'h1234_5680, 200, -1, 61);
        step(C_J, 1'b0, 1'b0);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        end
        $finish;
    end
endmodule